// File: doc/BRIEF.md
# Framed Command Packet Decoder

This block turns a stream of individually strobed bits into decoded trim commands. A bit receiver upstream presents one bit at a time on `bit_data` with a single-cycle `bit_valid` strobe. The bits may arrive back to back or with any number of idle cycles between them. The decoder shifts each accepted bit into a 38-bit register. The earliest bit ends up in the most significant position. When the 38th bit arrives, the decoder checks the whole word.

A word is accepted only if it satisfies three conditions. Its leading 12-bit marker must be correct, its trailing 12-bit marker must be correct, and a fixed 2-bit separator must sit between the parameter field and the value field. For an accepted word the block emits a one-cycle command strobe. The strobe carries the function, the parameter selector, and the value with the bits not used by that parameter forced to zero. A rejected word raises a one-cycle error flag instead. If the sender stalls in the middle of a word, a timeout discards the partial word so that a fresh word can start cleanly.

Top module: `frame_cmd_decoder`

## Requirements
- R1: `rst_n` is a synchronous, active-low reset. While it is low and on the cycle after it is released, `cmd_valid`, `frame_err` and `timeout_drop` are low. Bits received before the reset are discarded.
- R2: Bits are ordered MSB first. After 38 strobes, the first bit received is word bit 37. Word bits [37:26] hold the leading marker and [25:24] hold the function. Bits [23:22] hold the parameter, [21:20] hold the separator, [19:12] hold the value and [11:0] hold the trailing marker.
- R3: The leading marker must be 12'h801, the trailing marker must be 12'h7FE and the separator must be 2'b10. When all three match, `cmd_valid` is high for exactly one cycle, in the cycle after the clock edge that samples the 38th strobe.
- R4: During `cmd_valid`, `cmd_func` and `cmd_param` carry word bits [25:24] and [23:22]. Function codes are 00 for sense current, 01 for simulate, 10 for program and 11 for read. Parameter codes are 00 for second-stage gain, 01 for first-stage gain, 10 for output offset and 11 for other functions.
- R5: If either marker or the separator does not match, `frame_err` is high for one cycle at the time `cmd_valid` would have risen, and `cmd_valid` stays low. The bit count restarts, so the next 38 strobes form a new word.
- R6: `cmd_value` is masked according to the parameter. Parameter 00 keeps bits [2:0], parameter 01 keeps [6:0] and parameter 10 keeps [7:0]. Parameter 11 keeps [2:0]: bit 0 is the master fuse, bit 1 is the test fuse and bit 2 is the parity fuse. All other bits are zero.
- R7: Cycles with `bit_valid` low never shift or count. Any spacing between strobes yields the same result.
- R8: Suppose a word is partly received and `TIMEOUT_CYCLES` consecutive clock edges pass with no strobe. On the last of those edges the partial word is discarded, and `timeout_drop` is high for one cycle after it. A strobe on that expiring edge is accepted instead. With no partial word, no timeout occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bit_valid | input | 1 | One-cycle strobe: `bit_data` holds a bit |
| bit_data | input | 1 | Serial bit value |
| cmd_valid | output | 1 | One-cycle strobe for an accepted command |
| cmd_func | output | 2 | Decoded function code |
| cmd_param | output | 2 | Decoded parameter selector |
| cmd_value | output | 8 | Value with unused bits forced to zero |
| frame_err | output | 1 | One-cycle flag for a rejected word |
| timeout_drop | output | 1 | One-cycle flag for a discarded partial word |

## Verification
Suppose the bit counter is off by one. Then the marker check misaligns, and an otherwise good word raises `frame_err` one strobe early or late. The bench catches this on the very first word. Bit order and field placement faults appear as wrong `cmd_func`, `cmd_param` or `cmd_value` in that same strobe cycle. The masking fault is exercised with all-ones values for every parameter. A stuck idle timer shows up in two ways. A missing `timeout_drop` exactly `TIMEOUT_CYCLES` cycles after a stall is one sign. The other is a spurious error on the following word, because stale bits remain in the shift register.

// File: rtl/pd_pkg.sv
package pd_pkg;
    localparam int FRAME_W   = 38;
    localparam int MARK_W    = 12;
    localparam int VALUE_W   = 8;
    localparam logic [MARK_W-1:0] LEAD_MARK  = 12'h801;
    localparam logic [MARK_W-1:0] TRAIL_MARK = 12'h7FE;
    localparam logic [1:0]        SEP_CODE   = 2'b10;

    // bit positions inside the assembled word (first bit received at the top)
    localparam int LEAD_LSB  = FRAME_W - MARK_W;       // 26
    localparam int FUNC_LSB  = LEAD_LSB - 2;           // 24
    localparam int PARAM_LSB = FUNC_LSB - 2;           // 22
    localparam int SEP_LSB   = PARAM_LSB - 2;          // 20
    localparam int VAL_LSB   = SEP_LSB - VALUE_W;      // 12
    localparam int CNT_W     = $clog2(FRAME_W + 1);

    typedef enum logic [1:0] {
        FN_SENSE    = 2'b00,
        FN_SIMULATE = 2'b01,
        FN_PROGRAM  = 2'b10,
        FN_READ     = 2'b11
    } func_e;

    typedef enum logic [1:0] {
        PR_GAIN2  = 2'b00,
        PR_GAIN1  = 2'b01,
        PR_OFFSET = 2'b10,
        PR_MISC   = 2'b11
    } param_e;

    typedef struct packed {
        func_e               func;
        param_e              param;
        logic [VALUE_W-1:0]  value;
    } cmd_t;

    // number of value bits each parameter keeps
    function automatic int kept_bits(param_e p);
        case (p)
            PR_GAIN2:  return 3;
            PR_GAIN1:  return 7;
            PR_OFFSET: return 8;
            default:   return 3;
        endcase
    endfunction
endpackage

// File: rtl/pd_field_check.sv
module pd_field_check
    import pd_pkg::*;
(
    input  logic [FRAME_W-1:0] word,
    output cmd_t               raw_cmd,
    output logic               word_ok
);
    logic lead_ok;
    logic trail_ok;
    logic sep_ok;

    always_comb begin
        lead_ok       = (word[FRAME_W-1:LEAD_LSB] == LEAD_MARK);
        trail_ok      = (word[MARK_W-1:0] == TRAIL_MARK);
        sep_ok        = (word[SEP_LSB+1:SEP_LSB] == SEP_CODE);
        word_ok       = lead_ok && trail_ok && sep_ok;
        raw_cmd.func  = func_e'(word[FUNC_LSB+1:FUNC_LSB]);
        raw_cmd.param = param_e'(word[PARAM_LSB+1:PARAM_LSB]);
        raw_cmd.value = word[VAL_LSB+VALUE_W-1:VAL_LSB];
    end
endmodule

// File: rtl/pd_value_mask.sv
module pd_value_mask
    import pd_pkg::*;
(
    input  cmd_t raw_cmd,
    output cmd_t out_cmd
);
    logic [VALUE_W-1:0] keep;

    for (genvar i = 0; i < VALUE_W; i++) begin : g_keep
        always_comb keep[i] = (i < kept_bits(raw_cmd.param));
    end

    always_comb begin
        out_cmd       = raw_cmd;
        out_cmd.value = raw_cmd.value & keep;
    end
endmodule

// File: rtl/pd_idle_timer.sv
module pd_idle_timer #(
    parameter int LIMIT  = 1000,
    parameter int IDLE_W = $clog2(LIMIT + 1)
) (
    input  logic [IDLE_W-1:0] idle_q,
    input  logic              armed,
    input  logic              strobe,
    output logic [IDLE_W-1:0] idle_d,
    output logic              expire
);
    localparam logic [IDLE_W-1:0] LAST = IDLE_W'(LIMIT - 1);

    always_comb begin
        expire = 1'b0;
        idle_d = '0;
        if (armed && !strobe) begin
            if (idle_q == LAST) expire = 1'b1;
            else                idle_d = idle_q + 1'b1;
        end
    end
endmodule

// File: rtl/frame_cmd_decoder.sv
module frame_cmd_decoder
    import pd_pkg::*;
#(
    parameter int TIMEOUT_CYCLES = 1000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bit_valid,
    input  logic       bit_data,
    output logic       cmd_valid,
    output logic [1:0] cmd_func,
    output logic [1:0] cmd_param,
    output logic [7:0] cmd_value,
    output logic       frame_err,
    output logic       timeout_drop
);
    localparam int IDLE_W = $clog2(TIMEOUT_CYCLES + 1);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(FRAME_W - 1);

    typedef struct packed {
        logic [FRAME_W-1:0] sr;
        logic [CNT_W-1:0]   cnt;
        logic [IDLE_W-1:0]  idle;
        logic               valid;
        logic               err;
        logic               drop;
        cmd_t               cmd;
    } state_t;

    state_t s_q, s_d;

    logic [FRAME_W-1:0] word;
    cmd_t               raw_cmd;
    cmd_t               masked_cmd;
    logic               word_ok;
    logic [IDLE_W-1:0]  idle_next;
    logic               expire;

    assign word = {s_q.sr[FRAME_W-2:0], bit_data};

    pd_field_check u_check (
        .word    (word),
        .raw_cmd (raw_cmd),
        .word_ok (word_ok)
    );

    pd_value_mask u_mask (
        .raw_cmd (raw_cmd),
        .out_cmd (masked_cmd)
    );

    pd_idle_timer #(.LIMIT(TIMEOUT_CYCLES), .IDLE_W(IDLE_W)) u_idle (
        .idle_q (s_q.idle),
        .armed  (s_q.cnt != '0),
        .strobe (bit_valid),
        .idle_d (idle_next),
        .expire (expire)
    );

    always_comb begin
        s_d       = s_q;
        s_d.valid = 1'b0;
        s_d.err   = 1'b0;
        s_d.drop  = 1'b0;
        s_d.idle  = idle_next;
        if (bit_valid) begin
            if (s_q.cnt == LAST_BIT) begin
                s_d.sr  = '0;
                s_d.cnt = '0;
                if (word_ok) begin
                    s_d.valid = 1'b1;
                    s_d.cmd   = masked_cmd;
                end else begin
                    s_d.err = 1'b1;
                end
            end else begin
                s_d.sr  = word;
                s_d.cnt = s_q.cnt + 1'b1;
            end
        end else if (expire) begin
            s_d.sr   = '0;
            s_d.cnt  = '0;
            s_d.drop = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign cmd_valid    = s_q.valid;
    assign frame_err    = s_q.err;
    assign timeout_drop = s_q.drop;
    assign cmd_func     = s_q.cmd.func;
    assign cmd_param    = s_q.cmd.param;
    assign cmd_value    = s_q.cmd.value;
endmodule

// File: rtl/pd_checker.sv
module pd_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       bit_valid,
    input logic       cmd_valid,
    input logic [1:0] cmd_param,
    input logic [7:0] cmd_value,
    input logic       frame_err,
    input logic       timeout_drop
);
    a_r3_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |=> !cmd_valid);
    a_r3_after_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> $past(bit_valid));
    a_r5_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(cmd_valid && frame_err));
    a_r5_err_after_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        frame_err |-> $past(bit_valid));
    a_r6_mask_narrow: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_param != 2'b01 && cmd_param != 2'b10) |-> cmd_value[7:3] == 5'd0);
    a_r6_mask_seven: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_param == 2'b01) |-> !cmd_value[7]);
    a_r8_drop_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_drop |-> !$past(bit_valid));
    a_r8_drop_alone: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_drop |-> !(cmd_valid || frame_err));
endmodule

bind frame_cmd_decoder pd_checker u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .bit_valid    (bit_valid),
    .cmd_valid    (cmd_valid),
    .cmd_param    (cmd_param),
    .cmd_value    (cmd_value),
    .frame_err    (frame_err),
    .timeout_drop (timeout_drop)
);

// File: tb/frame_cmd_decoder_tb.sv
module frame_cmd_decoder_tb;
    localparam int TO = 20;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bit_valid = 1'b0;
    logic       bit_data = 1'b0;
    logic       cmd_valid;
    logic [1:0] cmd_func;
    logic [1:0] cmd_param;
    logic [7:0] cmd_value;
    logic       frame_err;
    logic       timeout_drop;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        int         kind;   // 0 command, 1 error, 2 drop
        logic [1:0] func;
        logic [1:0] param;
        logic [7:0] value;
        string      tag;
    } exp_t;

    exp_t expq[$];

    always #10 clk = ~clk;

    frame_cmd_decoder #(.TIMEOUT_CYCLES(TO)) u_dut (
        .clk(clk), .rst_n(rst_n), .bit_valid(bit_valid), .bit_data(bit_data),
        .cmd_valid(cmd_valid), .cmd_func(cmd_func), .cmd_param(cmd_param),
        .cmd_value(cmd_value), .frame_err(frame_err), .timeout_drop(timeout_drop)
    );

    task automatic check(input bit ok, input string tag, input string msg);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: %s", tag, msg);
        end
    endtask

    function automatic logic [37:0] mk(input logic [11:0] lead, input logic [1:0] f,
                                       input logic [1:0] p, input logic [1:0] sep,
                                       input logic [7:0] v, input logic [11:0] trail);
        return {lead, f, p, sep, v, trail};
    endfunction

    function automatic logic [7:0] mask(input logic [1:0] p, input logic [7:0] v);
        case (p)
            2'b01:   return v & 8'h7F;
            2'b10:   return v;
            default: return v & 8'h07;
        endcase
    endfunction

    // monitor: pops the scoreboard whenever an output event appears
    always @(negedge clk) begin
        if (rst_n && (cmd_valid || frame_err || timeout_drop)) begin
            if (expq.size() == 0) begin
                check(1'b0, "R5", $sformatf("unexpected event v=%b e=%b d=%b exp none",
                      cmd_valid, frame_err, timeout_drop));
            end else begin
                exp_t e;
                int got;
                e = expq.pop_front();
                got = cmd_valid ? 0 : (frame_err ? 1 : 2);
                check(got == e.kind, e.tag,
                      $sformatf("event kind act=%0d exp=%0d", got, e.kind));
                if (e.kind == 0 && got == 0)
                    check(cmd_func == e.func && cmd_param == e.param && cmd_value == e.value,
                          e.tag, $sformatf("fields act=%b/%b/%h exp=%b/%b/%h",
                          cmd_func, cmd_param, cmd_value, e.func, e.param, e.value));
            end
        end
    end

    // drive bits [hi:lo] of w; optional timing check after the 38th bit
    task automatic send_bits(input logic [37:0] w, input int hi, input int lo,
                             input int gap, input int last_kind, input string tag);
        for (int i = hi; i >= lo; i--) begin
            @(negedge clk);
            bit_valid = 1'b1;
            bit_data  = w[i];
            @(negedge clk);
            bit_valid = 1'b0;
            if (i == 0 && last_kind >= 0) begin
                check(last_kind == 0 ? cmd_valid : frame_err, tag,
                      $sformatf("strobe timing act v=%b e=%b exp kind %0d",
                      cmd_valid, frame_err, last_kind));
                @(negedge clk);
                check(!cmd_valid && !frame_err, tag,
                      $sformatf("pulse width act v=%b e=%b exp 0 0", cmd_valid, frame_err));
            end
            for (int g = 0; g < gap; g++) @(negedge clk);
        end
    endtask

    task automatic good_frame(input logic [1:0] f, input logic [1:0] p,
                              input logic [7:0] v, input int gap, input string tag);
        exp_t e;
        e.kind = 0; e.func = f; e.param = p; e.value = mask(p, v); e.tag = tag;
        expq.push_back(e);
        send_bits(mk(12'h801, f, p, 2'b10, v, 12'h7FE), 37, 0, gap, 0, tag);
    endtask

    task automatic bad_frame(input logic [37:0] w, input string tag);
        exp_t e;
        e.kind = 1; e.func = 0; e.param = 0; e.value = 0; e.tag = tag;
        expq.push_back(e);
        send_bits(w, 37, 0, 0, 1, tag);
    endtask

    initial begin
        #(20 * 150000);
        check(1'b0, "R1", "watchdog expired act=running exp=finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check(!cmd_valid && !frame_err && !timeout_drop, "R1",
              $sformatf("reset outputs act=%b%b%b exp=000", cmd_valid, frame_err, timeout_drop));
        rst_n = 1'b1;
        @(negedge clk);
        check(!cmd_valid && !frame_err && !timeout_drop, "R1", "outputs after release not low");

        // R2 R3 R4: basic frames with all functions and parameters
        good_frame(2'b10, 2'b10, 8'hA5, 0, "R4");
        good_frame(2'b00, 2'b01, 8'h3C, 0, "R2");
        good_frame(2'b11, 2'b10, 8'h81, 0, "R3");
        good_frame(2'b01, 2'b00, 8'h05, 0, "R4");
        // R6: all-ones value under each parameter
        for (int p = 0; p < 4; p++) good_frame(2'b10, 2'(p), 8'hFF, 0, "R6");
        good_frame(2'b01, 2'b11, 8'hFA, 0, "R6");
        // R7: spaced strobes
        good_frame(2'b10, 2'b01, 8'h6E, 3, "R7");
        // R5: each corrupted field, followed by a good frame (count restarted)
        bad_frame(mk(12'h800, 2'b10, 2'b10, 2'b10, 8'h11, 12'h7FE), "R5");
        good_frame(2'b10, 2'b10, 8'h22, 0, "R5");
        bad_frame(mk(12'h801, 2'b10, 2'b10, 2'b10, 8'h11, 12'h7FF), "R5");
        bad_frame(mk(12'h801, 2'b10, 2'b10, 2'b01, 8'h11, 12'h7FE), "R5");
        good_frame(2'b00, 2'b00, 8'h07, 0, "R5");

        // R8: stall on a partial word gives a drop exactly after TO idle edges
        begin
            exp_t e;
            e.kind = 2; e.func = 0; e.param = 0; e.value = 0; e.tag = "R8";
            expq.push_back(e);
            send_bits(mk(12'h801, 2'b10, 2'b10, 2'b10, 8'h99, 12'h7FE), 37, 28, 0, -1, "R8");
            for (int k = 0; k < TO - 1; k++) @(negedge clk);
            check(!timeout_drop, "R8", "drop one cycle early act=1 exp=0");
            @(negedge clk);
            check(timeout_drop, "R8", $sformatf("drop act=%b exp=1", timeout_drop));
        end
        good_frame(2'b10, 2'b01, 8'h44, 0, "R8");

        // R8: strobe on the expiring edge keeps the partial word
        begin
            exp_t e;
            logic [37:0] w;
            w = mk(12'h801, 2'b01, 2'b10, 2'b10, 8'h5A, 12'h7FE);
            e.kind = 0; e.func = 2'b01; e.param = 2'b10; e.value = 8'h5A; e.tag = "R8";
            expq.push_back(e);
            send_bits(w, 37, 20, 0, -1, "R8");
            for (int k = 0; k < TO - 2; k++) @(negedge clk);
            send_bits(w, 19, 0, 0, 0, "R8");
        end

        // R8: long idle with nothing pending makes no event (monitor flags any)
        for (int k = 0; k < 3 * TO; k++) @(negedge clk);

        // R1: reset in mid-word discards bits
        send_bits(mk(12'h801, 2'b10, 2'b10, 2'b10, 8'hCC, 12'h7FE), 37, 17, 0, -1, "R1");
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        good_frame(2'b11, 2'b11, 8'h03, 0, "R1");

        repeat (4) @(negedge clk);
        check(expq.size() == 0, "R3", $sformatf("pending events act=%0d exp=0", expq.size()));
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule